// File: doc/BRIEF.md
# Dual-Channel Split-Count PWM Generator

This peripheral drives two pulse-width-modulated outputs. Software does not give a period and a compare value. It gives each channel two 16-bit lengths: how many ticks the output stays high, and then how many ticks it stays low. The waveform repeats this high-then-low pair for as long as the channel runs. A tick is a strobe taken from one of four tick-enable inputs, picked per channel, and then divided by a per-channel 7-bit prescaler. The four strobes share the system clock, so no clock is ever switched.

A small word-addressed register interface holds the state. There is one count word per channel and one shared control word with the enables, clock gates, source selects and prescalers of both channels. There is no polarity setting: software inverts a waveform by exchanging its two lengths. Turning a channel off drops its output at once. Turning it on starts a fresh period with the high phase. Clearing its clock gate while it is enabled holds the waveform exactly where it is.

Top module: `dual_tick_pwm`

## Requirements
- R1: Byte offset 0x0 holds channel A's count word, 0x4 holds channel B's, and 0x8 holds the control word. All are zero after reset. A write is captured on the clock edge where `bus_wr` is high. `bus_rdata` shows the word at `bus_addr` one clock later. Count words read back all 32 bits as written. The control word reads back only its defined bits (mask 0x00FFFFF3), with all other bits zero. Offset 0xC reads zero.
- R2: In a count word, bits 31:16 are the high length and bits 15:0 are the low length, both unsigned.
- R3: Control word fields. Bit 0 is the A enable and bit 1 the B enable. Bits 5:4 are A's source select and bits 7:6 B's. Bits 14:8 are A's prescaler and bits 22:16 B's. Bit 15 is A's clock gate and bit 23 B's.
- R4: With both lengths non-zero, the output is high for exactly `hi` divided ticks, then low for exactly `lo` divided ticks, and this repeats.
- R5: A divided tick occurs once every (prescaler + 1) strobes of the selected source, so a prescaler of 0 passes each strobe through.
- R6: A source select value of n makes the channel count strobes on `src_tick[n]`.
- R7: A low length of 0 with a non-zero high length holds the output high. A high length of 0 holds the output low. Both lengths 0 hold it low.
- R8: When the enable bit is cleared, the output is low from the next clock edge on. The period in progress is abandoned.
- R9: When the enable bit is set, the prescaler and phase counter restart. The output goes high on the clock edge after the control write, and the first high phase has its full length.
- R10: A count word written while its channel runs does not affect the current period. It takes effect when the next high phase begins.
- R11: While the enable is set and the clock gate is clear, the prescaler, phase counter and output level hold. The waveform resumes from the same point once the gate is set again.
- R12: The two channels run at the same time and do not affect each other's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register interface |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| src_tick | input | 4 | Tick-enable strobes for the four sources |
| pwm_o | output | 2 | PWM outputs, bit 0 channel A, bit 1 channel B |

## Verification
The bench measures high and low lengths in system clocks across several prescaler values and two slower sources. A design that swapped the count fields, or divided by the prescaler value instead of the prescaler plus one, would produce lengths that are off. Zero-length cases are held over long windows, because an off-by-one phase step would show up there as a single glitch cycle. Disable, re-enable and clock-gate freezes are timed to the cycle; a design that let the period finish, or that resumed instead of restarting, would stay high too long or start with a short first pulse. A count rewrite in mid-high checks that the old period completes before the new lengths take over.

// File: rtl/tickpwm_pkg.sv
package tickpwm_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 7;
  localparam int SEL_W  = 2;
  localparam int NSRC   = 1 << SEL_W;
  localparam int NCH    = 2;

  typedef struct packed {
    logic             en;
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } chan_cfg_t;

  typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;
endpackage

// File: rtl/tickpwm_regs.sv
module tickpwm_regs
  import tickpwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output chan_cfg_t         cfg [NCH]
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int CTRL_IDX  = NCH;
  localparam int EN_BASE   = 0;
  localparam int SEL_BASE  = 4;
  localparam int PRE_BASE  = 8;
  localparam int GATE_BASE = 15;
  localparam int STRIDE    = 8;

  function automatic logic [DATA_W-1:0] ctrl_mask_f();
    logic [DATA_W-1:0] m = '0;
    for (int c = 0; c < NCH; c++) begin
      m[EN_BASE + c] = 1'b1;
      m[SEL_BASE + SEL_W*c +: SEL_W] = '1;
      m[PRE_BASE + STRIDE*c +: PRE_W] = '1;
      m[GATE_BASE + STRIDE*c] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask_f();

  logic [WORD_W-1:0] word;
  logic              addr_unused;
  logic [DATA_W-1:0] cnt_q [NCH];
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rd_mux;

  assign word        = bus_addr[ADDR_W-1:2];
  assign addr_unused = ^bus_addr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      for (int c = 0; c < NCH; c++) cnt_q[c] <= '0;
    end else if (bus_wr) begin
      for (int c = 0; c < NCH; c++)
        if (word == WORD_W'(c)) cnt_q[c] <= bus_wdata;
      if (word == WORD_W'(CTRL_IDX)) ctrl_q <= bus_wdata & CTRL_MASK;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++)
      if (word == WORD_W'(c)) rd_mux = cnt_q[c];
    if (word == WORD_W'(CTRL_IDX)) rd_mux = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cfg
    assign cfg[c].en   = ctrl_q[EN_BASE + c];
    assign cfg[c].gate = ctrl_q[GATE_BASE + STRIDE*c];
    assign cfg[c].sel  = ctrl_q[SEL_BASE + SEL_W*c +: SEL_W];
    assign cfg[c].pre  = ctrl_q[PRE_BASE + STRIDE*c +: PRE_W];
    assign cfg[c].hi   = cnt_q[c][DATA_W-1 -: CNT_W];
    assign cfg[c].lo   = cnt_q[c][CNT_W-1:0];
  end

  // R1: reading the control word never shows undefined bits
  p_rd_masked_r1: assert property (@(posedge clk) disable iff (rst)
    (word == WORD_W'(CTRL_IDX)) |=> ((bus_rdata & ~CTRL_MASK) == '0));
endmodule

// File: rtl/tickpwm_chan.sv
module tickpwm_chan
  import tickpwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  chan_cfg_t       cfg,
  input  logic [NSRC-1:0] src_tick,
  output logic            pwm_o
);
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q, hi_q, lo_q;
  logic [PRE_W-1:0] pre_q;
  logic             run, tick, div_tick, phase_last, level;

  assign run      = cfg.en & cfg.gate;
  assign tick     = run & src_tick[cfg.sel];
  assign div_tick = tick & (pre_q >= cfg.pre);

  always_comb begin
    if (ph_q == PH_HIGH) begin
      phase_last = (hi_q == '0) || (cnt_q == hi_q - 1'b1);
      level      = (hi_q != '0);
    end else begin
      phase_last = (lo_q == '0) || (cnt_q == lo_q - 1'b1);
      level      = (lo_q == '0) && (hi_q != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
      pre_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      pwm_o <= 1'b0;
    end else if (!cfg.en) begin
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
      pre_q <= '0;
      hi_q  <= cfg.hi;
      lo_q  <= cfg.lo;
      pwm_o <= 1'b0;
    end else begin
      pwm_o <= level;
      if (tick) pre_q <= div_tick ? '0 : pre_q + 1'b1;
      if (div_tick) begin
        if (phase_last) begin
          cnt_q <= '0;
          if (ph_q == PH_HIGH) begin
            ph_q <= PH_LOW;
          end else begin
            ph_q <= PH_HIGH;
            hi_q <= cfg.hi;
            lo_q <= cfg.lo;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R4: the phase counter stays inside the active phase length
  p_cnt_high_r4: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_HIGH && hi_q != '0) |-> (cnt_q < hi_q));
  p_cnt_low_r4: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_LOW && lo_q != '0) |-> (cnt_q < lo_q));
  // R11: a closed clock gate holds all timing state
  p_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg.en && !cfg.gate) |=> ($stable(cnt_q) && $stable(pre_q) && $stable(ph_q) && $stable(pwm_o)));
  // R8 / R9: a disabled channel is low and parked at the period start
  p_off_parked_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg.en |=> (!pwm_o && cnt_q == '0 && pre_q == '0 && ph_q == PH_HIGH));
endmodule

// File: rtl/dual_tick_pwm.sv
module dual_tick_pwm
  import tickpwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_tick,
  output logic [NCH-1:0]    pwm_o
);
  chan_cfg_t cfg [NCH];

  tickpwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg       (cfg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tickpwm_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .cfg      (cfg[c]),
      .src_tick (src_tick),
      .pwm_o    (pwm_o[c])
    );
  end
endmodule

// File: tb/dual_tick_pwm_test.sv
module dual_tick_pwm_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = 4'b0001;
  logic [1:0]  pwm_o;

  int checks = 0;
  int errors = 0;
  int phase_ctr = 0;

  dual_tick_pwm uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // source 0 every clock, 1 every 2nd, 2 every 3rd, 3 never
  always @(negedge clk) begin
    phase_ctr <= phase_ctr + 1;
    src_tick  <= {1'b0, ((phase_ctr + 1) % 3 == 0), ((phase_ctr + 1) % 2 == 0), 1'b1};
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(bit ea, bit ga, int sa, int pa,
                                      bit eb, bit gb, int sb, int pb);
    logic [31:0] v = '0;
    v[0] = ea; v[1] = eb;
    v[5:4] = 2'(sa); v[7:6] = 2'(sb);
    v[14:8] = 7'(pa); v[15] = ga;
    v[22:16] = 7'(pb); v[23] = gb;
    return v;
  endfunction

  function automatic logic [31:0] cw(int hi, int lo);
    return {16'(hi), 16'(lo)};
  endfunction

  task automatic wait_level(int ch, bit v);
    int n = 0;
    while (pwm_o[ch] != v && n < LIMIT) begin n++; @(negedge clk); end
  endtask

  task automatic run_len(int ch, bit v, output int n);
    n = 0;
    while (pwm_o[ch] == v && n < LIMIT) begin n++; @(negedge clk); end
  endtask

  task automatic measure(int ch, int exp_hi, int exp_lo, string req);
    int h, l;
    wait_level(ch, 1'b0);
    wait_level(ch, 1'b1);
    run_len(ch, 1'b1, h);
    run_len(ch, 1'b0, l);
    check({req, " high length"}, h, exp_hi);
    check({req, " low length"}, l, exp_lo);
  endtask

  task automatic hold_check(int ch, bit v, int n, string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_o[ch] != v) bad++;
      @(negedge clk);
    end
    check(req, bad, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 reset outputs low", pwm_o, 0);
    rd(4'h0, d); check("R1 reset count A", d, 0);
    rd(4'h4, d); check("R1 reset count B", d, 0);
    rd(4'h8, d); check("R1 reset control", d, 0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(4'h0, 32'hDEAD_BEEF);
    wr(4'h4, 32'h1234_5678);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFF00_000C);
    rd(4'h0, d); check("R1 count A readback", d, 32'hDEAD_BEEF);
    rd(4'h4, d); check("R1 count B readback", d, 32'h1234_5678);
    rd(4'h8, d); check("R1 control undefined bits zero", d, 0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); check("R1 control masked readback", d, 32'h00FF_FFF3);
    rd(4'hC, d); check("R1 offset 0xC reads zero", d, 0);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_basic;
    wr(4'h8, 0);
    wr(4'h0, cw(3, 5));
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    measure(0, 3, 5, "R2 R4 hi3 lo5 pre0");
    wr(4'h8, 0);
    wr(4'h0, cw(3, 2));
    wr(4'h8, ctl(1, 1, 0, 2, 0, 0, 0, 0));
    measure(0, 9, 6, "R3 R5 hi3 lo2 pre2");
    wr(4'h8, 0);
  endtask

  task automatic t_source;
    wr(4'h0, cw(2, 3));
    wr(4'h8, ctl(1, 1, 1, 0, 0, 0, 0, 0));
    measure(0, 4, 6, "R6 source1 pre0");
    wr(4'h8, 0);
    wr(4'h0, cw(2, 1));
    wr(4'h8, ctl(1, 1, 2, 1, 0, 0, 0, 0));
    measure(0, 12, 6, "R6 R5 source2 pre1");
    wr(4'h8, 0);
  endtask

  task automatic t_const;
    wr(4'h0, cw(5, 0));
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    hold_check(0, 1'b1, 60, "R7 low length 0 stays high");
    wr(4'h8, 0);
    wr(4'h0, cw(0, 5));
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    hold_check(0, 1'b0, 60, "R7 high length 0 stays low");
    wr(4'h8, 0);
    wr(4'h0, cw(0, 0));
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    hold_check(0, 1'b0, 60, "R7 both lengths 0 stay low");
    wr(4'h8, 0);
  endtask

  task automatic t_disable_restart;
    int h;
    wr(4'h0, cw(20, 20));
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    wait_level(0, 1'b1);
    repeat (2) @(negedge clk);
    wr(4'h8, ctl(0, 1, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    check("R8 low one clock after disable", pwm_o[0], 0);
    hold_check(0, 1'b0, 30, "R8 stays low while disabled");
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    check("R9 still low right after enable write", pwm_o[0], 0);
    @(negedge clk);
    check("R9 high one clock after enable", pwm_o[0], 1);
    run_len(0, 1'b1, h);
    check("R9 first high phase full length", h, 20);
    wr(4'h8, 0);
  endtask

  task automatic t_update;
    int h, l;
    wr(4'h0, cw(3, 5));
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    wait_level(0, 1'b0);
    wait_level(0, 1'b1);
    wr(4'h0, cw(6, 2));
    run_len(0, 1'b1, h);
    h = h + 1;
    run_len(0, 1'b0, l);
    check("R10 current high keeps old length", h, 3);
    check("R10 current low keeps old length", l, 5);
    run_len(0, 1'b1, h);
    run_len(0, 1'b0, l);
    check("R10 next high uses new length", h, 6);
    check("R10 next low uses new length", l, 2);
    wr(4'h8, 0);
  endtask

  task automatic t_gate;
    int h, l;
    wr(4'h0, cw(20, 20));
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    wait_level(0, 1'b1);
    repeat (4) @(negedge clk);
    wr(4'h8, ctl(1, 0, 0, 0, 0, 0, 0, 0));
    hold_check(0, 1'b1, 40, "R11 output held while gated");
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    run_len(0, 1'b1, h);
    run_len(0, 1'b0, l);
    check("R11 remaining high after ungate", h, 15);
    check("R11 low after resume", l, 20);
    wr(4'h8, 0);
  endtask

  task automatic t_dual;
    wr(4'h0, cw(4, 4));
    wr(4'h4, cw(2, 6));
    wr(4'h8, ctl(1, 1, 0, 0, 1, 1, 0, 1));
    measure(0, 4, 4, "R12 channel A beside B");
    measure(1, 4, 12, "R12 channel B beside A");
    measure(0, 4, 4, "R12 channel A again");
    wr(4'h8, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_readback;
    t_basic;
    t_source;
    t_const;
    t_disable_restart;
    t_update;
    t_gate;
    t_dual;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule